// File: doc/BRIEF.md
# Watchdog Second-Timeout Status and Reboot Control

This block sits beside a watchdog counter. It records what happens when the watchdog expires a second time. A second expiry counts only if it arrives while the counter's first-timeout flag is still raised and software has not reloaded the counter since that flag came up. A counted expiry does three things:

- It latches a sticky second-timeout flag.
- It latches a boot-failure flag when the processor has not yet fetched its first instruction.
- It starts a fixed-length platform reset pulse, unless the no-reboot configuration bit holds it back.

While the boot-failure flag is set, a reboot started by a second expiry drives the clock-multiplier select to the all-ones safe code. The select stays forced until software clears the boot-failure flag. At all other times the programmed multiplier passes through. Both flags sit in a 16-bit status word and are cleared by writing ones to them. The resume-well reset also clears them. The platform reset pulse does not touch them, so they survive the reboot they cause.

Top module: `wdog_reboot_status`

## Requirements
- R1: A second expiry is qualified when all of the following hold: `expire_i` is high, `first_to_i` is high, `reload_i` is low in that cycle, and no `reload_i` has been seen since `first_to_i` last went high. A qualified expiry sets the second-timeout flag (status bit 1) at the next clock edge.
- R2: An expiry that is not qualified has no effect on the flags, the reset pulse or the multiplier select. This covers an expiry while `first_to_i` is low, and an expiry after a reload while `first_to_i` stayed high.
- R3: The boot-failure flag (status bit 2) sets at the same edge as the second-timeout flag goes 0 to 1, and only if `cpu_fetched_i` is low. A qualified expiry while the second-timeout flag is already 1 never sets it.
- R4: A qualified expiry with `no_reboot_i` low drives `plat_rst_o` high for exactly PULSE_LEN (default 16) cycles. The pulse starts at the edge where the flag sets. With `no_reboot_i` high there is no pulse. An expiry during an active pulse does not lengthen it.
- R5: When a reboot starts and the boot-failure flag is set at that edge, `mult_sel_o` reads 4'b1111 from that edge on. It holds that value until the boot-failure flag is cleared. Otherwise `mult_sel_o` is `prog_mult_i` registered by one cycle. It is 0 after reset.
- R6: A cycle with `wr_en_i` high clears each flag whose bit in `wr_data_i` is 1. Bits written as 0 have no effect. Clearing the boot-failure flag works even while the second-timeout flag is still set.
- R7: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R8: `status_o` carries the second-timeout flag in bit 1 and the boot-failure flag in bit 2. Bit 0 and bits 15:3 always read 0.
- R9: `rst` clears both flags, ends the pulse and resets `mult_sel_o` to 0. The end of a platform reset pulse leaves both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high resume-well reset |
| first_to_i | input | 1 | First-timeout flag level from the watchdog counter |
| reload_i | input | 1 | One-cycle strobe when software reloads the watchdog |
| expire_i | input | 1 | One-cycle pulse on a watchdog expiry |
| no_reboot_i | input | 1 | Configuration bit that suppresses the reboot |
| cpu_fetched_i | input | 1 | High once the processor has fetched its first instruction |
| wr_en_i | input | 1 | Status register write strobe |
| wr_data_i | input | 16 | Write data; a 1 in a flag bit clears that flag |
| prog_mult_i | input | 4 | Normal programmed multiplier code |
| status_o | output | 16 | Status word |
| plat_rst_o | output | 1 | Platform reset pulse |
| mult_sel_o | output | 4 | Multiplier select driven to the clock hardware |

## Verification
The bench runs every combination of no-reboot, fetched state and all sixteen programmed multiplier codes through a second expiry. It checks flags, pulse length and the multiplier in each combination. A design that keyed the safe code off the fetched input instead of the boot-failure flag would fail on the no-reboot rows. A design that dropped the forcing once the pulse ended would fail when the bench reads the select after the pulse.

The bench also drives these corner cases:

- An expiry after a reload, which a design that ignores reload history would count.
- A set and a clear in the same cycle, which a clear-wins design would lose.
- A repeat expiry while the second-timeout flag is still set, which an edge-blind design would answer with a false boot failure.
- An expiry in mid-pulse, which a retriggering counter would stretch.

// File: rtl/wdrs_pkg.sv
package wdrs_pkg;
  // Status word layout: software decodes these positions.
  localparam int unsigned SEC_POS  = 1;
  localparam int unsigned BOOT_POS = 2;

  typedef struct packed {
    logic boot;
    logic sec;
  } wdrs_flags_t;
endpackage

// File: rtl/wdrs_qualify.sv
// Decides whether an expiry pulse counts as a second timeout.
module wdrs_qualify (
  input  logic clk,
  input  logic rst,
  input  logic first_to_i,
  input  logic reload_i,
  input  logic expire_i,
  output logic qual_o
);
  logic reload_seen_q;

  // Remembers a reload made while the first-timeout flag is up.
  always_ff @(posedge clk) begin
    if (rst) begin
      reload_seen_q <= 1'b0;
    end else if (!first_to_i) begin
      reload_seen_q <= 1'b0;
    end else if (reload_i) begin
      reload_seen_q <= 1'b1;
    end
  end

  assign qual_o = expire_i & first_to_i & ~reload_i & ~reload_seen_q;
endmodule

// File: rtl/wdrs_flags.sv
// Sticky second-timeout and boot-failure flags, write-one-to-clear, set wins.
module wdrs_flags
  import wdrs_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        qual_i,
  input  logic        fetched_i,
  input  logic        clr_sec_i,
  input  logic        clr_boot_i,
  output wdrs_flags_t flags_o,
  output wdrs_flags_t flags_d_o
);
  wdrs_flags_t q, d;
  logic        boot_set;

  always_comb begin
    boot_set = qual_i & ~q.sec & ~fetched_i;
    d.sec    = qual_i   | (q.sec  & ~clr_sec_i);
    d.boot   = boot_set | (q.boot & ~clr_boot_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q <= d;
    end
  end

  assign flags_o   = q;
  assign flags_d_o = d;
endmodule

// File: rtl/wdrs_pulse.sv
// Fixed-length, non-retriggerable platform reset pulse.
module wdrs_pulse #(
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic launch_o,
  output logic active_o
);
  localparam int unsigned CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  assign launch_o = start_i & ~active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (launch_o) begin
      active_q <= 1'b1;
      cnt_q    <= CNT_W'(PULSE_LEN - 1);
    end else if (active_q) begin
      if (cnt_q == '0) begin
        active_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/wdrs_mult.sv
// Multiplier select: safe code after a reboot with boot failure, else pass-through.
module wdrs_mult #(
  parameter int unsigned        MULT_W    = 4,
  parameter logic [MULT_W-1:0]  SAFE_MULT = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch_i,
  input  logic              boot_d_i,
  input  logic [MULT_W-1:0] prog_i,
  output logic [MULT_W-1:0] mult_o
);
  logic safe_q, safe_d;

  assign safe_d = boot_d_i & (launch_i | safe_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      safe_q <= 1'b0;
      mult_o <= '0;
    end else begin
      safe_q <= safe_d;
      mult_o <= safe_d ? SAFE_MULT : prog_i;
    end
  end
endmodule

// File: rtl/wdog_reboot_status.sv
module wdog_reboot_status
  import wdrs_pkg::*;
#(
  parameter int unsigned       REG_W     = 16,
  parameter int unsigned       MULT_W    = 4,
  parameter logic [MULT_W-1:0] SAFE_MULT = '1,
  parameter int unsigned       PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              first_to_i,
  input  logic              reload_i,
  input  logic              expire_i,
  input  logic              no_reboot_i,
  input  logic              cpu_fetched_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [MULT_W-1:0] prog_mult_i,
  output logic [REG_W-1:0]  status_o,
  output logic              plat_rst_o,
  output logic [MULT_W-1:0] mult_sel_o
);
  localparam logic [REG_W-1:0] FLAG_MASK =
    (REG_W'(1) << SEC_POS) | (REG_W'(1) << BOOT_POS);

  logic        qual, launch;
  wdrs_flags_t flags, flags_d;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] wr_rsvd_unused;

  assign clr_vec        = {REG_W{wr_en_i}} & wr_data_i & FLAG_MASK;
  assign wr_rsvd_unused = wr_data_i & ~FLAG_MASK;

  wdrs_qualify u_qual (
    .clk        (clk),
    .rst        (rst),
    .first_to_i (first_to_i),
    .reload_i   (reload_i),
    .expire_i   (expire_i),
    .qual_o     (qual)
  );

  wdrs_flags u_flags (
    .clk        (clk),
    .rst        (rst),
    .qual_i     (qual),
    .fetched_i  (cpu_fetched_i),
    .clr_sec_i  (clr_vec[SEC_POS]),
    .clr_boot_i (clr_vec[BOOT_POS]),
    .flags_o    (flags),
    .flags_d_o  (flags_d)
  );

  wdrs_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk      (clk),
    .rst      (rst),
    .start_i  (qual & ~no_reboot_i),
    .launch_o (launch),
    .active_o (plat_rst_o)
  );

  wdrs_mult #(.MULT_W(MULT_W), .SAFE_MULT(SAFE_MULT)) u_mult (
    .clk      (clk),
    .rst      (rst),
    .launch_i (launch),
    .boot_d_i (flags_d.boot),
    .prog_i   (prog_mult_i),
    .mult_o   (mult_sel_o)
  );

  // Status word: flag bits from the flops, every other bit tied low.
  for (genvar b = 0; b < REG_W; b++) begin : g_status
    if (b == SEC_POS) begin : g_sec
      assign status_o[b] = flags.sec;
    end else if (b == BOOT_POS) begin : g_boot
      assign status_o[b] = flags.boot;
    end else begin : g_rsvd
      assign status_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/wdog_reboot_status_chk.sv
module wdog_reboot_status_chk
  import wdrs_pkg::*;
#(
  parameter int unsigned       REG_W     = 16,
  parameter int unsigned       MULT_W    = 4,
  parameter logic [MULT_W-1:0] SAFE_MULT = '1,
  parameter int unsigned       PULSE_LEN = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              first_to_i,
  input logic              expire_i,
  input logic              no_reboot_i,
  input logic              cpu_fetched_i,
  input logic              wr_en_i,
  input logic [REG_W-1:0]  wr_data_i,
  input logic [REG_W-1:0]  status_o,
  input logic              plat_rst_o,
  input logic [MULT_W-1:0] mult_sel_o
);
  localparam int unsigned HW = $clog2(PULSE_LEN + 1) + 1;
  localparam logic [REG_W-1:0] FLAG_MASK =
    (REG_W'(1) << SEC_POS) | (REG_W'(1) << BOOT_POS);

  logic [HW-1:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (rst || !plat_rst_o) hi_cnt <= '0;
    else                    hi_cnt <= hi_cnt + 1'b1;
  end

  // R1
  sec_needs_expiry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[SEC_POS]) |-> $past(expire_i && first_to_i));

  // R3
  boot_needs_unfetched_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[BOOT_POS]) |-> $past(!cpu_fetched_i) && status_o[SEC_POS]
                                  && $past(!status_o[SEC_POS]));

  // R4
  pulse_needs_reboot_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(plat_rst_o) |-> $past(expire_i && !no_reboot_i));

  // R4
  pulse_max_len_chk: assert property (@(posedge clk) disable iff (rst)
    plat_rst_o |-> hi_cnt < HW'(PULSE_LEN));

  // R4
  pulse_full_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(plat_rst_o) && !$past(rst) |-> hi_cnt == HW'(PULSE_LEN));

  // R5
  safe_mult_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(plat_rst_o) && status_o[BOOT_POS] |-> mult_sel_o == SAFE_MULT);

  // R6
  sec_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en_i && wr_data_i[SEC_POS] && !expire_i) |-> !status_o[SEC_POS]);

  // R8
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (status_o & ~FLAG_MASK) == '0);
endmodule

bind wdog_reboot_status wdog_reboot_status_chk #(
  .REG_W(REG_W), .MULT_W(MULT_W), .SAFE_MULT(SAFE_MULT), .PULSE_LEN(PULSE_LEN)
) u_chk (
  .clk(clk), .rst(rst), .first_to_i(first_to_i), .expire_i(expire_i),
  .no_reboot_i(no_reboot_i), .cpu_fetched_i(cpu_fetched_i), .wr_en_i(wr_en_i),
  .wr_data_i(wr_data_i), .status_o(status_o), .plat_rst_o(plat_rst_o),
  .mult_sel_o(mult_sel_o)
);

// File: tb/tb_wdog_reboot_status.sv
module tb_wdog_reboot_status;
  localparam int PL = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        first_to_i = 0, reload_i = 0, expire_i = 0, no_reboot_i = 0;
  logic        cpu_fetched_i = 0, wr_en_i = 0;
  logic [15:0] wr_data_i = '0;
  logic [3:0]  prog_mult_i = '0;
  logic [15:0] status_o;
  logic        plat_rst_o;
  logic [3:0]  mult_sel_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wdog_reboot_status dut (
    .clk(clk), .rst(rst), .first_to_i(first_to_i), .reload_i(reload_i),
    .expire_i(expire_i), .no_reboot_i(no_reboot_i), .cpu_fetched_i(cpu_fetched_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .prog_mult_i(prog_mult_i),
    .status_o(status_o), .plat_rst_o(plat_rst_o), .mult_sel_o(mult_sel_o)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; first_to_i = 0; reload_i = 0; expire_i = 0; wr_en_i = 0;
    wr_data_i = '0; no_reboot_i = 0; cpu_fetched_i = 0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic pulse_expire();
    expire_i = 1'b1; tick(); expire_i = 1'b0;
  endtask

  task automatic write_w1c(input logic [15:0] v);
    wr_en_i = 1'b1; wr_data_i = v; tick(); wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic count_pulse(output int n);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      if (!plat_rst_o) break;
      n++;
      tick();
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    tick();
    do_reset();
    // R9 reset state
    chk("R9 status after reset", 32'(status_o), 32'h0);
    chk("R9 pulse after reset", 32'(plat_rst_o), 32'h0);
    chk("R9 mult after reset", 32'(mult_sel_o), 32'h0);

    // R2: expiry with first-timeout low is ignored
    pulse_expire();
    chk("R2 no first_to: status", 32'(status_o), 32'h0);
    chk("R2 no first_to: pulse", 32'(plat_rst_o), 32'h0);
    // R2: reload after first timeout blocks the expiry
    first_to_i = 1'b1; tick();
    reload_i = 1'b1; tick(); reload_i = 1'b0; tick();
    pulse_expire();
    chk("R2 reloaded: status", 32'(status_o), 32'h0);
    chk("R2 reloaded: pulse", 32'(plat_rst_o), 32'h0);
    // R1: first-timeout drops and rises again, so the expiry counts
    first_to_i = 1'b0; tick(); first_to_i = 1'b1; tick();
    pulse_expire();
    chk("R1 qualified sets sec", 32'(status_o[1]), 32'h1);

    // Sweep: no-reboot x fetched x every programmed multiplier
    for (int nr = 0; nr < 2; nr++) begin
      for (int fe = 0; fe < 2; fe++) begin
        for (int pm = 0; pm < 16; pm++) begin
          logic [3:0] exp_mult;
          do_reset();
          first_to_i = 1'b1; no_reboot_i = nr[0]; cpu_fetched_i = fe[0];
          prog_mult_i = pm[3:0];
          tick();
          chk("R5 pass-through", 32'(mult_sel_o), 32'(pm));
          pulse_expire();
          exp_mult = (nr == 0 && fe == 0) ? 4'hF : pm[3:0];
          chk("R1 sec set", 32'(status_o[1]), 32'h1);
          chk("R3 boot set iff unfetched", 32'(status_o[2]), 32'(fe == 0));
          chk("R5 mult at reboot start", 32'(mult_sel_o), 32'(exp_mult));
          count_pulse(n);
          chk("R4 pulse length", 32'(n), (nr == 0) ? 32'(PL) : 32'h0);
          chk("R9 flags survive pulse", 32'(status_o), (fe == 0) ? 32'h6 : 32'h2);
          if (nr == 0 && fe == 0) begin
            chk("R5 safe held after pulse", 32'(mult_sel_o), 32'hF);
            write_w1c(16'h0004);
            chk("R6 boot cleared with sec set", 32'(status_o), 32'h2);
            chk("R5 release to programmed", 32'(mult_sel_o), 32'(pm));
          end
        end
      end
    end

    // R7: set and clear collide
    do_reset();
    first_to_i = 1'b1; prog_mult_i = 4'h5; tick();
    expire_i = 1'b1; wr_en_i = 1'b1; wr_data_i = 16'h0006;
    tick();
    expire_i = 1'b0; wr_en_i = 1'b0; wr_data_i = '0;
    chk("R7 set wins", 32'(status_o), 32'h6);
    chk("R8 layout and reserved bits", 32'(status_o & 16'hFFF9), 32'h0);
    // R6: zero bits in the write have no effect
    write_w1c(16'hFFF9);
    chk("R6 zero bits ignored", 32'(status_o), 32'h6);
    // R4: an expiry in mid-pulse does not stretch it (one cycle used above)
    n = 1;
    for (int i = 0; i < 40; i++) begin
      if (!plat_rst_o) break;
      n++;
      expire_i = (i == 4);
      tick();
    end
    expire_i = 1'b0;
    chk("R4 no retrigger", 32'(n), 32'(PL));
    // R3: repeat expiry with sec already set leaves boot clear
    write_w1c(16'h0004);
    tick();
    pulse_expire();
    chk("R3 no boot on repeat", 32'(status_o), 32'h2);
    chk("R4 new pulse started", 32'(plat_rst_o), 32'h1);
    chk("R5 no force without boot", 32'(mult_sel_o), 32'h5);
    write_w1c(16'h0002);
    chk("R6 sec cleared", 32'(status_o), 32'h0);

    // R9: reset in mid-pulse with both flags set
    do_reset();
    first_to_i = 1'b1; tick();
    pulse_expire();
    tick();
    rst = 1'b1; tick();
    chk("R9 reset clears flags", 32'(status_o), 32'h0);
    chk("R9 reset ends pulse", 32'(plat_rst_o), 32'h0);
    chk("R9 reset mult", 32'(mult_sel_o), 32'h0);
    rst = 1'b0; tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule